// File: doc/BRIEF.md
# Composite Sync Mixer with Serration and Equalization

This block merges separately timed horizontal and vertical sync and blank signals into one composite sync and one composite blank. Composite blank is the plain union of the two blanking signals. Composite sync is the union of the two sync signals on ordinary lines. While vertical sync is asserted, the block puts broad serration pulses in its place. Equalization pulses fill a programmable number of lines just before and just after that interval.

Both pulse shapes are set by compares against the horizontal pixel counter. Each compare is measured from the pixel where the front porch ends. The equalization pulse is a short sync pulse that starts at the porch end and stops at a programmed pixel. The serration pulse starts at a programmed pixel and lasts until the porch end of the next period. A rate control picks one pulse per line or two per line. For two per line, the compares repeat in the second half of the line, shifted by half the line length. Interlaced operation always uses two per line. A polarity control picks active-high or active-low outputs. Both outputs are registered on the falling clock edge, so they line up with the horizontal timing signals.

Top module: `csync_mixer`

## Requirements
- R1: `cblank` carries `hblank | vblank`, sampled at one falling clock edge and presented from that edge on.
- R2: Outside the serration and equalization zones, `csync` carries `hsync | vsync`, with the same one-falling-edge latency as R1.
- R3: The pulse phase equals `hcount` in single rate. In double rate it equals `hcount - hmax/2` when `hcount > hmax/2`, and `hcount` otherwise. `hmax` is even.
- R4: The equalization pulse is active for phase values `porch_end <= phase < eq_end`.
- R5: The serration pulse is active for phase values `phase < porch_end` or `phase >= serr_start`.
- R6: While `vsync` is high, `csync` follows the serration pulse, and `hsync` has no effect.
- R7: On lines with `vsync` low, `csync` follows the equalization pulse, and `hsync` has no effect. This applies to the pre-zone, `vs_first - N <= vline < vs_first`, and to the post-zone, `vs_after <= vline < vs_after + N`. N is the equalization line count.
- R8: The equalization line count resets to 3. A falling edge with `eq_wr` high loads `eq_wdata`. A count of 0 removes both zones.
- R9: `interlace` high forces double rate, whatever the value of `dbl_rate`.
- R10: With `pol_high` = 1, both outputs are high when active. With `pol_high` = 0, both outputs are inverted. During reset, both outputs sit at their inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hcount | input | HW | Horizontal pixel counter, 1 to hmax |
| hmax | input | HW | Line length in pixels (even) |
| porch_end | input | HW | Pixel where front porch ends; start of equalization |
| eq_end | input | HW | Pixel where the equalization pulse ends |
| serr_start | input | HW | Pixel where the serration pulse starts |
| vline | input | VW | Vertical line counter |
| vs_first | input | VW | First line of vertical sync |
| vs_after | input | VW | First line after vertical sync |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| hblank | input | 1 | Horizontal blank, active high |
| vblank | input | 1 | Vertical blank, active high |
| dbl_rate | input | 1 | Select two pulses per line |
| interlace | input | 1 | Interlaced operation; forces double rate |
| eq_wr | input | 1 | Load strobe for the equalization line count |
| eq_wdata | input | EQW | New equalization line count |
| pol_high | input | 1 | 1 = active-high outputs, 0 = active-low |
| csync | output | 1 | Composite sync |
| cblank | output | 1 | Composite blank |

## Verification
The bench starts with directed cases. Pixel positions sit on either side of each compare value and on either side of the half-line point. These separate off-by-one errors in the pulse windows from errors in folding the second half of the line. Lines at the edges of the pre-zone and post-zone are driven with the default count and with reprogrammed counts. These show whether the zone bounds and the reset value of the count are right. Random cycles then mix sync and blank levels, line numbers, rate, interlace and polarity. Hsync is driven high inside the zones, which tells substituted pulses apart from a plain OR mix.

// File: rtl/csync_mix_pkg.sv
package csync_mix_pkg;
  typedef enum logic [1:0] {
    ZN_PLAIN   = 2'd0,
    ZN_EQ_PRE  = 2'd1,
    ZN_SERR    = 2'd2,
    ZN_EQ_POST = 2'd3
  } csm_zone_e;
endpackage

// File: rtl/csm_phase.sv
module csm_phase #(
  parameter int HW = 12
) (
  input  logic [HW-1:0] hcount,
  input  logic [HW-1:0] hmax,
  input  logic          dbl,
  output logic [HW-1:0] phase
);
  // fold the second half of the line onto the first in double rate
  function automatic logic [HW-1:0] fold(input logic [HW-1:0] h,
                                         input logic [HW-1:0] m,
                                         input logic          d);
    logic [HW-1:0] half;
    half = m >> 1;
    if (d && (h > half)) return h - half;
    return h;
  endfunction

  assign phase = fold(hcount, hmax, dbl);
endmodule

// File: rtl/csm_pulse.sv
module csm_pulse #(
  parameter int HW = 12
) (
  input  logic [HW-1:0] phase,
  input  logic [HW-1:0] porch_end,
  input  logic [HW-1:0] eq_end,
  input  logic [HW-1:0] serr_start,
  output logic          eq_pulse,
  output logic          serr_pulse
);
  function automatic logic in_span(input logic [HW-1:0] p,
                                   input logic [HW-1:0] lo,
                                   input logic [HW-1:0] hi);
    return (p >= lo) && (p < hi);
  endfunction

  assign eq_pulse   = in_span(phase, porch_end, eq_end);
  assign serr_pulse = (phase < porch_end) || (phase >= serr_start);
endmodule

// File: rtl/csm_zone.sv
module csm_zone
  import csync_mix_pkg::*;
#(
  parameter int VW       = 11,
  parameter int EQW      = 4,
  parameter int EQ_RESET = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [VW-1:0]  vline,
  input  logic [VW-1:0]  vs_first,
  input  logic [VW-1:0]  vs_after,
  input  logic           vsync,
  input  logic           eq_wr,
  input  logic [EQW-1:0] eq_wdata,
  output csm_zone_e      zone,
  output logic [EQW-1:0] eq_lines_q
);
  localparam int SW = ((VW > EQW) ? VW : EQW) + 1;

  logic [SW-1:0] line_x, first_x, after_x, eq_x;
  logic          in_pre, in_post;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)      eq_lines_q <= EQW'(EQ_RESET);
    else if (eq_wr)  eq_lines_q <= eq_wdata;
  end

  assign line_x  = SW'(vline);
  assign first_x = SW'(vs_first);
  assign after_x = SW'(vs_after);
  assign eq_x    = SW'(eq_lines_q);

  assign in_pre  = (line_x + eq_x >= first_x) && (line_x < first_x);
  assign in_post = (line_x >= after_x) && (line_x < after_x + eq_x);

  always_comb begin
    if (vsync)        zone = ZN_SERR;
    else if (in_pre)  zone = ZN_EQ_PRE;
    else if (in_post) zone = ZN_EQ_POST;
    else              zone = ZN_PLAIN;
  end
endmodule

// File: rtl/csync_mixer.sv
module csync_mixer
  import csync_mix_pkg::*;
#(
  parameter int HW       = 12,
  parameter int VW       = 11,
  parameter int EQW      = 4,
  parameter int EQ_RESET = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  hcount,
  input  logic [HW-1:0]  hmax,
  input  logic [HW-1:0]  porch_end,
  input  logic [HW-1:0]  eq_end,
  input  logic [HW-1:0]  serr_start,
  input  logic [VW-1:0]  vline,
  input  logic [VW-1:0]  vs_first,
  input  logic [VW-1:0]  vs_after,
  input  logic           hsync,
  input  logic           vsync,
  input  logic           hblank,
  input  logic           vblank,
  input  logic           dbl_rate,
  input  logic           interlace,
  input  logic           eq_wr,
  input  logic [EQW-1:0] eq_wdata,
  input  logic           pol_high,
  output logic           csync,
  output logic           cblank
);
  logic           dbl_active;
  logic [HW-1:0]  phase;
  logic           eq_pulse, serr_pulse;
  csm_zone_e      zone;
  logic [EQW-1:0] eq_lines_q;
  logic           cs_next, cs_q, cb_q;

  assign dbl_active = dbl_rate | interlace;

  csm_phase #(.HW(HW)) u_phase (
    .hcount (hcount),
    .hmax   (hmax),
    .dbl    (dbl_active),
    .phase  (phase)
  );

  csm_pulse #(.HW(HW)) u_pulse (
    .phase      (phase),
    .porch_end  (porch_end),
    .eq_end     (eq_end),
    .serr_start (serr_start),
    .eq_pulse   (eq_pulse),
    .serr_pulse (serr_pulse)
  );

  csm_zone #(.VW(VW), .EQW(EQW), .EQ_RESET(EQ_RESET)) u_zone (
    .clk        (clk),
    .rst_n      (rst_n),
    .vline      (vline),
    .vs_first   (vs_first),
    .vs_after   (vs_after),
    .vsync      (vsync),
    .eq_wr      (eq_wr),
    .eq_wdata   (eq_wdata),
    .zone       (zone),
    .eq_lines_q (eq_lines_q)
  );

  always_comb begin
    unique case (zone)
      ZN_SERR:               cs_next = serr_pulse;
      ZN_EQ_PRE, ZN_EQ_POST: cs_next = eq_pulse;
      default:               cs_next = hsync | vsync;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      cb_q <= 1'b0;
    end else begin
      cs_q <= cs_next;
      cb_q <= hblank | vblank;
    end
  end

  assign csync  = pol_high ? cs_q : ~cs_q;
  assign cblank = pol_high ? cb_q : ~cb_q;
endmodule

// File: rtl/csync_mixer_chk.sv
module csync_mixer_chk
  import csync_mix_pkg::*;
#(
  parameter int EQW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hsync,
  input logic           vsync,
  input logic           hblank,
  input logic           vblank,
  input logic           interlace,
  input logic           dbl_active,
  input csm_zone_e      zone,
  input logic           eq_pulse,
  input logic           serr_pulse,
  input logic           eq_wr,
  input logic [EQW-1:0] eq_wdata,
  input logic [EQW-1:0] eq_lines_q,
  input logic           pol_high,
  input logic           csync,
  input logic           cblank
);
  logic cs_act, cb_act;
  assign cs_act = pol_high ? csync : ~csync;
  assign cb_act = pol_high ? cblank : ~cblank;

  p_blank_mix_r1: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |=> cb_act == $past(hblank | vblank));

  p_plain_mix_r2: assert property (@(negedge clk) disable iff (!rst_n)
    zone == ZN_PLAIN |=> cs_act == $past(hsync | vsync));

  p_serration_r6: assert property (@(negedge clk) disable iff (!rst_n)
    zone == ZN_SERR |=> cs_act == $past(serr_pulse));

  p_equalize_r7: assert property (@(negedge clk) disable iff (!rst_n)
    (zone == ZN_EQ_PRE || zone == ZN_EQ_POST) |=> cs_act == $past(eq_pulse));

  p_serr_on_vsync_r6: assert property (@(negedge clk) disable iff (!rst_n)
    vsync |-> zone == ZN_SERR);

  p_eq_load_r8: assert property (@(negedge clk) disable iff (!rst_n)
    eq_wr |=> eq_lines_q == $past(eq_wdata));

  p_interlace_dbl_r9: assert property (@(negedge clk) disable iff (!rst_n)
    interlace |-> dbl_active);
endmodule

bind csync_mixer csync_mixer_chk #(.EQW(EQW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hsync      (hsync),
  .vsync      (vsync),
  .hblank     (hblank),
  .vblank     (vblank),
  .interlace  (interlace),
  .dbl_active (dbl_active),
  .zone       (zone),
  .eq_pulse   (eq_pulse),
  .serr_pulse (serr_pulse),
  .eq_wr      (eq_wr),
  .eq_wdata   (eq_wdata),
  .eq_lines_q (eq_lines_q),
  .pol_high   (pol_high),
  .csync      (csync),
  .cblank     (cblank)
);

// File: tb/tb_csync_mixer.sv
`timescale 1ns/1ps
module tb_csync_mixer;
  localparam int HW = 12, VW = 11, EQW = 4;
  localparam int HM = 100, R1 = 5, R9 = 9, R10 = 43, VS0 = 20, VS1 = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] hcount = 1, hmax = HM, porch_end = R1, eq_end = R9, serr_start = R10;
  logic [VW-1:0] vline = 1, vs_first = VS0, vs_after = VS1;
  logic hsync = 0, vsync = 0, hblank = 0, vblank = 0;
  logic dbl_rate = 0, interlace = 0, eq_wr = 0, pol_high = 1;
  logic [EQW-1:0] eq_wdata = 0;
  logic csync, cblank;

  int checks = 0, errors = 0, eqn = 3;
  bit done = 0;

  always #2.5 clk = ~clk;

  csync_mixer #(.HW(HW), .VW(VW), .EQW(EQW)) dut (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .hmax(hmax),
    .porch_end(porch_end), .eq_end(eq_end), .serr_start(serr_start),
    .vline(vline), .vs_first(vs_first), .vs_after(vs_after),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .dbl_rate(dbl_rate), .interlace(interlace), .eq_wr(eq_wr),
    .eq_wdata(eq_wdata), .pol_high(pol_high), .csync(csync), .cblank(cblank)
  );

  function automatic int model_phase(int h, bit dbl);
    if (dbl && h > HM / 2) return h - HM / 2;
    return h;
  endfunction

  function automatic bit model_cs(int h, int ln, bit hs, bit vs, bit dbl, int n);
    int p;
    bit eqp, srp;
    p   = model_phase(h, dbl);
    eqp = (p >= R1) && (p < R9);
    srp = (p < R1) || (p >= R10);
    if (vs) return srp;
    if ((ln + n >= VS0 && ln < VS0) || (ln >= VS1 && ln < VS1 + n)) return eqp;
    return hs | vs;
  endfunction

  task automatic check(string req, bit got, bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b (hcount=%0d line=%0d)", req, got, exp, hcount, vline);
    end
  endtask

  // apply inputs (at posedge+1), let the falling edge capture, compare outputs
  task automatic run(string req, int h, int ln, bit hs, bit vs, bit hb, bit vb,
                     bit dbl, bit il, bit pol);
    bit act, bact;
    hcount = HW'(h); vline = VW'(ln); hsync = hs; vsync = vs;
    hblank = hb; vblank = vb; dbl_rate = dbl; interlace = il; pol_high = pol;
    act  = model_cs(h, ln, hs, vs, dbl | il, eqn);
    bact = hb | vb;
    @(negedge clk); #1;
    check(req, csync, pol ? act : ~act);
    check("R1", cblank, pol ? bact : ~bact);
    @(posedge clk); #1;
  endtask

  task automatic load_eq(int n);
    eq_wr = 1'b1; eq_wdata = EQW'(n);
    @(negedge clk); #1;
    eq_wr = 1'b0; eqn = n;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sd;
    void'($urandom(32'h5eed_0715));
    // reset state, R10: inactive level under both polarities
    hblank = 1; hsync = 1;
    repeat (3) @(posedge clk); #1;
    check("R10", csync, 1'b0); check("R10", cblank, 1'b0);
    pol_high = 0; #1;
    check("R10", csync, 1'b1); check("R10", cblank, 1'b1);
    pol_high = 1;
    @(posedge clk); #1; rst_n = 1'b1;

    // R2 plain mix, R1 blank
    run("R2", 50, 5, 1, 0, 0, 1, 0, 0, 1);
    run("R2", 50, 5, 0, 0, 1, 0, 0, 0, 1);
    // R8 default count of 3: line VS0-3 is equalized, VS0-4 plain
    run("R8", 50, VS0 - 3, 1, 0, 0, 0, 0, 0, 1);
    run("R8", 50, VS0 - 4, 1, 0, 0, 0, 0, 0, 1);
    run("R7", 50, VS1 + 2, 1, 0, 0, 0, 0, 0, 1);
    run("R7", 50, VS1 + 3, 1, 0, 0, 0, 0, 0, 1);
    // R4 equalization edges
    run("R4", R1 - 1, VS0 - 1, 0, 0, 0, 0, 0, 0, 1);
    run("R4", R1,     VS0 - 1, 0, 0, 0, 0, 0, 0, 1);
    run("R4", R9 - 1, VS0 - 1, 0, 0, 0, 0, 0, 0, 1);
    run("R4", R9,     VS0 - 1, 1, 0, 0, 0, 0, 0, 1);
    // R5/R6 serration edges, hsync ignored
    run("R5", R10 - 1, VS0, 1, 1, 0, 0, 0, 0, 1);
    run("R5", R10,     VS0, 0, 1, 0, 0, 0, 0, 1);
    run("R6", R1,      VS0, 1, 1, 0, 0, 0, 0, 1);
    run("R6", R1 - 1,  VS0, 0, 1, 0, 0, 0, 0, 1);
    // R3 half-line fold in double rate
    run("R3", HM / 2,      VS0, 0, 1, 0, 0, 1, 0, 1);
    run("R3", HM / 2 + 1,  VS0, 0, 1, 0, 0, 1, 0, 1);
    run("R3", HM / 2 + R1, VS1, 0, 0, 0, 0, 1, 0, 1);
    run("R3", HM / 2 + R1, VS1, 1, 0, 0, 0, 0, 0, 1);
    // R9 interlace forces double rate
    run("R9", HM / 2 + R1, VS1, 0, 0, 0, 0, 0, 1, 1);
    run("R9", HM / 2 + R10 - 1, VS0, 0, 1, 0, 0, 0, 1, 1);
    // R10 active-low outputs
    run("R10", 50, 5, 1, 0, 1, 0, 0, 0, 0);
    run("R10", 50, 5, 0, 0, 0, 0, 0, 0, 0);
    // R8 reprogrammed counts, zero removes zones
    load_eq(0);
    run("R8", 50, VS0 - 1, 1, 0, 0, 0, 0, 0, 1);
    run("R8", 50, VS1, 1, 0, 0, 0, 0, 0, 1);
    load_eq(6);
    run("R8", 50, VS0 - 6, 1, 0, 0, 0, 0, 0, 1);
    run("R8", 50, VS1 + 5, 1, 0, 0, 0, 0, 0, 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int h, ln;
      bit vs;
      if (i % 100 == 0) load_eq($urandom_range(0, 7));
      h  = $urandom_range(1, HM);
      ln = $urandom_range(8, 34);
      vs = (ln >= VS0 && ln < VS1) ? 1'b1 : ($urandom_range(0, 9) == 0);
      sd = $urandom_range(0, 255);
      run(vs ? "R6" : "R7", h, ln, sd[0], vs, sd[1], sd[2], sd[3], sd[4] & sd[5], sd[6] | sd[7]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule